// File: doc/BRIEF.md
# Low-Power Lane Request Detector

This block sits behind the low-power receivers of a serial data lane and watches the two single-ended line levels. While the lane idles in its stop condition (both lines high), the transmitting side announces what it wants to do next by stepping the line pair through a short series of levels. The detector recognizes three such announcements: a request to enter escape mode, a request to start a high-speed burst, and a request to turn the bus around. It reports each one as a single-cycle pulse.

The raw line pair is first passed through a stability filter. A level is accepted only after it has been sampled unchanged for a programmable number of clock cycles. Shorter glitches are discarded. The accepted levels drive a small sequencer. The three requests share their opening steps, so the sequencer must hold a partial match until the level that tells them apart arrives.

A step that does not fit any request raises a one-cycle error pulse. After an error, and after any completed request, the detector ignores the lines until the stop condition is accepted again.

The line pair is presented as a 2-bit vector. Bit 1 carries the positive line and bit 0 the negative line, so the state "LP-10" is the value 2'b10.

Top module: `lp_req_detector`

## Requirements
- R1: During and after reset, all four output pulses are low and the detector is armed, as if the stop state 2'b11 had been accepted.
- R2: A line level is accepted only after it has been sampled unchanged on STABLE_CYCLES consecutive clock edges (default 2). A level held for fewer edges has no effect on any output.
- R3: From the armed state, the accepted sequence 2'b10, 2'b00, 2'b01, 2'b00 produces exactly one pulse on `esc_req_o`.
- R4: From the armed state, the accepted sequence 2'b01, 2'b00 produces exactly one pulse on `hs_req_o`.
- R5: From the armed state, the accepted sequence 2'b10, 2'b00, 2'b10, 2'b00 produces exactly one pulse on `turn_req_o`.
- R6: Every output pulse is high for exactly one cycle, and at most one of the four outputs is high in any cycle. A request pulse appears two cycles after the clock edge on which its final 2'b00 completes qualification.
- R7: An accepted level that fits no request from the current partial match (including 2'b00 directly from armed) produces one `seq_err_o` pulse. After that, every level other than 2'b11 is ignored until 2'b11 is accepted.
- R8: If 2'b11 is accepted in the middle of a partial match, the detector produces one `seq_err_o` pulse and re-arms at once, so a new request may follow straight away.
- R9: After a completed request, the detector produces no further pulse of any kind until 2'b11 is accepted. After that it is armed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lines_i | input | 2 | Sampled line pair: bit 1 positive line, bit 0 negative line |
| esc_req_o | output | 1 | One-cycle pulse: escape-mode request recognized |
| hs_req_o | output | 1 | One-cycle pulse: high-speed burst request recognized |
| turn_req_o | output | 1 | One-cycle pulse: bus turnaround request recognized |
| seq_err_o | output | 1 | One-cycle pulse: accepted level illegal for the partial sequence |

## Verification
The bench targets the point where escape and turnaround separate after 2'b10, 2'b00. A sequencer that commits too early would report the wrong request there. It also injects glitches one cycle long in the middle of sequences. A filter that accepts them would report spurious errors or break up valid requests. The bench checks that lines are ignored after an error until stop returns, and that stop returning mid-sequence re-arms at once. A design that stays armed after an error would emit phantom requests, and one that waits for a second stop would miss the next request. Finally, the bench drives request-like patterns after a completed request to catch a detector that re-arms without seeing stop.

// File: rtl/lp_req_pkg.sv
package lp_req_pkg;

    typedef enum logic [1:0] {
        LN_00 = 2'b00,
        LN_01 = 2'b01,
        LN_10 = 2'b10,
        LN_11 = 2'b11
    } lp_line_e;

    typedef enum logic [2:0] {
        SQ_ARMED,
        SQ_SAW10,
        SQ_SAW10_00,
        SQ_ESC_01,
        SQ_TURN_10,
        SQ_HS_01,
        SQ_BLOCKED,
        SQ_ENGAGED
    } seq_state_e;

    typedef struct packed {
        logic esc;
        logic hs;
        logic turn;
        logic err;
    } req_pulse_t;

    typedef struct packed {
        seq_state_e nxt;
        req_pulse_t pulse;
    } seq_step_t;

    // A partial match that receives an unexpected level
    function automatic seq_step_t seq_fault(lp_line_e ln);
        seq_step_t r;
        r.pulse     = '0;
        r.pulse.err = 1'b1;
        r.nxt       = (ln == LN_11) ? SQ_ARMED : SQ_BLOCKED;
        return r;
    endfunction

    // Transition of the request sequencer on one accepted level
    function automatic seq_step_t seq_step(seq_state_e s, lp_line_e ln);
        seq_step_t r;
        r.nxt   = s;
        r.pulse = '0;
        case (s)
            SQ_ARMED: begin
                if (ln == LN_10)      r.nxt = SQ_SAW10;
                else if (ln == LN_01) r.nxt = SQ_HS_01;
                else if (ln == LN_00) r = seq_fault(ln);
            end
            SQ_SAW10: begin
                if (ln == LN_00) r.nxt = SQ_SAW10_00;
                else             r = seq_fault(ln);
            end
            SQ_SAW10_00: begin
                if (ln == LN_01)      r.nxt = SQ_ESC_01;
                else if (ln == LN_10) r.nxt = SQ_TURN_10;
                else                  r = seq_fault(ln);
            end
            SQ_ESC_01: begin
                if (ln == LN_00) begin
                    r.nxt       = SQ_ENGAGED;
                    r.pulse.esc = 1'b1;
                end else r = seq_fault(ln);
            end
            SQ_TURN_10: begin
                if (ln == LN_00) begin
                    r.nxt        = SQ_ENGAGED;
                    r.pulse.turn = 1'b1;
                end else r = seq_fault(ln);
            end
            SQ_HS_01: begin
                if (ln == LN_00) begin
                    r.nxt      = SQ_ENGAGED;
                    r.pulse.hs = 1'b1;
                end else r = seq_fault(ln);
            end
            default: begin
                if (ln == LN_11) r.nxt = SQ_ARMED;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lp_line_filter.sv
module lp_line_filter
    import lp_req_pkg::*;
#(
    parameter int STABLE_CYCLES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic [1:0] lines_i,
    output logic     evt_o,
    output lp_line_e evt_state_o
);
    localparam int CNT_W = (STABLE_CYCLES < 2) ? 1 : $clog2(STABLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(STABLE_CYCLES);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    lp_line_e         cand_q;
    lp_line_e         qual_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    lp_line_e         ln_now;
    logic             accept;

    always_comb begin
        ln_now = lp_line_e'(lines_i);
        if (ln_now != cand_q)      cnt_nx = CNT_ONE;
        else if (cnt_q >= CNT_LIM) cnt_nx = CNT_LIM;
        else                       cnt_nx = cnt_q + CNT_ONE;
        accept = (cnt_nx >= CNT_LIM) && (ln_now != qual_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q      <= LN_11;
            qual_q      <= LN_11;
            cnt_q       <= CNT_LIM;
            evt_o       <= 1'b0;
            evt_state_o <= LN_11;
        end else begin
            cand_q <= ln_now;
            cnt_q  <= cnt_nx;
            evt_o  <= accept;
            if (accept) begin
                qual_q      <= ln_now;
                evt_state_o <= ln_now;
            end
        end
    end

    // R2: an accepted level equals the line value sampled on the qualifying edge
    assert_evt_matches_line_R2: assert property (@(posedge clk) disable iff (rst)
        evt_o |-> ($past(lines_i) == evt_state_o));

    // R2: two accepted events never come on back-to-back cycles when filtering is active
    assert_evt_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        (evt_o && (STABLE_CYCLES > 1)) |=> !evt_o);

endmodule

// File: rtl/lp_req_sequencer.sv
module lp_req_sequencer
    import lp_req_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       evt_i,
    input  lp_line_e   evt_state_i,
    output req_pulse_t pulse_o
);
    seq_state_e st_q;
    seq_step_t  step;

    always_comb begin
        step = seq_step(st_q, evt_state_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SQ_ARMED;
            pulse_o <= '0;
        end else if (evt_i) begin
            st_q    <= step.nxt;
            pulse_o <= step.pulse;
        end else begin
            pulse_o <= '0;
        end
    end

    // R6: a request pulse only follows an accepted 2'b00
    assert_req_after_00_R6: assert property (@(posedge clk) disable iff (rst)
        (pulse_o.esc || pulse_o.hs || pulse_o.turn) |->
            ($past(evt_i) && ($past(evt_state_i) == LN_00)));

    // R8: accepting the stop level always leaves the sequencer armed
    assert_stop_rearms_R8: assert property (@(posedge clk) disable iff (rst)
        (evt_i && (evt_state_i == LN_11)) |=> (st_q == SQ_ARMED));

    // R9: after a request, the next accepted non-stop level gives no pulse
    assert_quiet_after_req_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_ENGAGED && evt_i && evt_state_i != LN_11) |=> (pulse_o == '0));

endmodule

// File: rtl/lp_req_detector.sv
module lp_req_detector
    import lp_req_pkg::*;
#(
    parameter int STABLE_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] lines_i,
    output logic       esc_req_o,
    output logic       hs_req_o,
    output logic       turn_req_o,
    output logic       seq_err_o
);
    logic       evt;
    lp_line_e   evt_state;
    req_pulse_t pulses;

    lp_line_filter #(
        .STABLE_CYCLES(STABLE_CYCLES)
    ) u_filter (
        .clk        (clk),
        .rst        (rst),
        .lines_i    (lines_i),
        .evt_o      (evt),
        .evt_state_o(evt_state)
    );

    lp_req_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt),
        .evt_state_i(evt_state),
        .pulse_o    (pulses)
    );

    assign esc_req_o  = pulses.esc;
    assign hs_req_o   = pulses.hs;
    assign turn_req_o = pulses.turn;
    assign seq_err_o  = pulses.err;

    // R6: at most one output active in any cycle
    assert_one_output_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({esc_req_o, hs_req_o, turn_req_o, seq_err_o}));

    // R6: no output stays high two cycles in a row
    assert_single_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        (esc_req_o || hs_req_o || turn_req_o || seq_err_o) |=>
            !(esc_req_o || hs_req_o || turn_req_o || seq_err_o));

    // R1: outputs low in the cycle after a reset edge
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> !(esc_req_o || hs_req_o || turn_req_o || seq_err_o));

endmodule

// File: tb/sim_lp_req_detector.sv
module sim_lp_req_detector;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] lines = 2'b11;
    logic       esc, hs, turn, err;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    int    exp_code_q[$];
    string exp_tag_q[$];

    always #2.5 clk = ~clk;

    lp_req_detector u0 (
        .clk       (clk),
        .rst       (rst),
        .lines_i   (lines),
        .esc_req_o (esc),
        .hs_req_o  (hs),
        .turn_req_o(turn),
        .seq_err_o (err)
    );

    // codes: 1 escape, 2 high-speed, 3 turnaround, 4 error, 7 several at once
    function automatic int out_code();
        int n;
        n = int'(esc) + int'(hs) + int'(turn) + int'(err);
        if (n == 0) return 0;
        if (n > 1)  return 7;
        if (esc)  return 1;
        if (hs)   return 2;
        if (turn) return 3;
        return 4;
    endfunction

    task automatic expect_out(int code, string tag);
        exp_code_q.push_back(code);
        exp_tag_q.push_back(tag);
    endtask

    task automatic drive(logic [1:0] v, int n);
        @(negedge clk);
        lines = v;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic expect_drained(string tag);
        checks++;
        if (exp_code_q.size() != 0) begin
            failures++;
            $display("FAIL %s: pending expected outputs actual=%0d expected=0", tag, exp_code_q.size());
            exp_code_q.delete();
            exp_tag_q.delete();
        end
    endtask

    // monitor: pops expected items as the design produces pulses
    int prev_code = 0;
    always @(negedge clk) begin
        int c;
        string t;
        if (!rst) begin
            c = out_code();
            if (prev_code != 0) begin
                checks++;
                if (c == prev_code) begin
                    failures++;
                    $display("FAIL R6: pulse width actual=2+ expected=1 code=%0d", c);
                end
            end
            if (c != 0 && !(prev_code != 0 && c == prev_code)) begin
                checks++;
                if (exp_code_q.size() == 0) begin
                    failures++;
                    $display("FAIL R2/R7/R9: unexpected output actual=%0d expected=none", c);
                end else begin
                    t = exp_tag_q.pop_front();
                    if (c != exp_code_q.pop_front()) begin
                        failures++;
                        $display("FAIL %s: output code actual=%0d expected other", t, c);
                    end
                end
            end
            prev_code = c;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 200000 && !done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: cycles actual=%0d expected<200000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_code() != 0) begin
            failures++;
            $display("FAIL R1: outputs in reset actual=%0d expected=0", out_code());
        end
        rst = 1'b0;
        drive(2'b11, 4);
        checks++;
        if (out_code() != 0) begin
            failures++;
            $display("FAIL R1: outputs after reset actual=%0d expected=0", out_code());
        end

        // R3 escape request
        expect_out(1, "R3");
        drive(2'b10, 4); drive(2'b00, 4); drive(2'b01, 4); drive(2'b00, 4);
        drive(2'b10, 4); drive(2'b11, 4);
        expect_drained("R3");

        // R4 high-speed request
        expect_out(2, "R4");
        drive(2'b01, 4); drive(2'b00, 4); drive(2'b11, 4);
        expect_drained("R4");

        // R5 turnaround request
        expect_out(3, "R5");
        drive(2'b10, 4); drive(2'b00, 4); drive(2'b10, 4); drive(2'b00, 4);
        drive(2'b11, 4);
        expect_drained("R5");

        // R2 one-cycle glitches ignored: at stop, then inside a high-speed request
        drive(2'b10, 1); drive(2'b11, 4);
        drive(2'b00, 1); drive(2'b11, 4);
        expect_drained("R2");
        expect_out(2, "R2");
        drive(2'b01, 4); drive(2'b00, 1); drive(2'b01, 4); drive(2'b10, 1);
        drive(2'b01, 3); drive(2'b00, 4); drive(2'b11, 4);
        expect_drained("R2");

        // R7 00 straight from stop: error, then lines ignored until stop
        expect_out(4, "R7");
        drive(2'b00, 4); drive(2'b10, 4); drive(2'b00, 4); drive(2'b01, 4);
        drive(2'b00, 4); drive(2'b11, 4);
        expect_drained("R7");
        expect_out(2, "R7");
        drive(2'b01, 4); drive(2'b00, 4); drive(2'b11, 4);
        expect_drained("R7");

        // R7 wrong level after the shared prefix
        expect_out(4, "R7");
        drive(2'b10, 4); drive(2'b00, 4); drive(2'b01, 4); drive(2'b10, 4);
        drive(2'b00, 4); drive(2'b11, 4);
        expect_drained("R7");

        // R8 stop mid-sequence, then an immediate request
        expect_out(4, "R8");
        expect_out(3, "R8");
        drive(2'b10, 4); drive(2'b11, 4);
        drive(2'b10, 4); drive(2'b00, 4); drive(2'b10, 4); drive(2'b00, 4);
        drive(2'b11, 4);
        expect_drained("R8");

        // R9 after escape request, request-like patterns give nothing
        expect_out(1, "R9");
        drive(2'b10, 4); drive(2'b00, 4); drive(2'b01, 4); drive(2'b00, 4);
        drive(2'b01, 4); drive(2'b00, 4); drive(2'b10, 4); drive(2'b00, 4);
        expect_drained("R9");
        expect_out(2, "R9");
        drive(2'b11, 4); drive(2'b01, 4); drive(2'b00, 4); drive(2'b11, 4);
        expect_drained("R9");

        // R6 request pulse lands two cycles after the qualifying edge
        drive(2'b01, 4);
        @(negedge clk); lines = 2'b00;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (hs) begin
            failures++;
            $display("FAIL R6: early pulse actual=1 expected=0");
        end
        exp_code_q.push_back(2); exp_tag_q.push_back("R6");
        drive(2'b00, 3); drive(2'b11, 4);
        expect_drained("R6");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule